// File: doc/BRIEF.md
# Packed-Field Real-Time Clock Core

This core keeps elapsed time as a single 32-bit word split into a day count, hours, minutes and seconds. It advances on a timebase tick. That tick comes either from a prescaler that divides a 32.768 kHz strobe down to one pulse per second, or straight from the strobe when the prescaler is switched off. Each tick can raise second, minute, hour and day-rollover events. A countdown stopwatch can raise an event, and so can two alarm comparators. One comparator matches the time of day only. The other matches the full day-and-time word.

Every event sets a sticky bit in a status register. A bit is cleared by writing a one to it, and the clear takes effect on the next cycle. An enable register selects which status bits drive the single interrupt line. Software reaches the registers through a small port: one write strobe, a word address, write data, and read data that follows the address combinationally. The core runs on the system clock. The 32.768 kHz input is a one-cycle strobe that is already synchronous to that clock.

Top module: `rtc_packed_core`

## Requirements
- R1: Register word addresses are 0 time, 1 control (bit 0 = prescaler enable), 2 alarm, 3 stopwatch, 4 status, 5 interrupt enable. The time and alarm words hold the second in bits 5:0, the minute in bits 11:6, the hour in bits 16:12 and the day in bits 31:17. Reset sets every register to zero and clears the interrupt line.
- R2: On each tick the second field increments. A second of 59 or more wraps to 0 and carries into the minute field, which wraps the same way. An hour of 23 or more wraps to 0 and carries into the day count.
- R3: The day count wraps from 32767 to 0, and this wrap raises no event beyond those that R5 names.
- R4: With the prescaler enable at 0, every strobe pulse is a tick. With it at 1, only every PRESCALE_DIV-th pulse is a tick, counted from the moment of enabling. Without a tick the time is unchanged.
- R5: Status bit 2 sets on every tick. Bit 3 sets on a tick where the second wraps. Bit 4 sets when the minute wraps as well. Bit 5 sets when the hour wraps as well.
- R6: Status bit 1 sets on a tick whose new time matches the alarm's hour, minute and second, whatever the day.
- R7: Status bit 6 sets on a tick whose new time matches all four alarm fields.
- R8: A nonzero stopwatch decrements on each tick. The tick that takes it from 1 to 0 sets status bit 0. A stopwatch that is already zero stays at zero and raises no event.
- R9: Status bits are set whatever the enable register holds. The interrupt line is high only while some status bit and its matching enable bit are both set.
- R10: Writing the status register clears the bits written as one by the next cycle. The other bits are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick32k_i | input | 1 | One-cycle strobe at the 32.768 kHz rate |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
Time, stopwatch and status all update on the clock edge that samples a tick, so each of them can be read in the cycle after the strobe. The interrupt line follows status and enable with no further delay. The bench raises each strobe for one cycle between falling edges and reads back only at the next falling edge. Register writes are sampled on one edge and read at the falling edge after it. For the prescaler, the bench counts exactly PRESCALE_DIV-1 pulses and checks that the time has not moved. It then sends one more pulse and checks the step. A reference model in the bench predicts the new time word and the accumulated status from random start times and alarms.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  // Packed time word: day in the top bits down to second in the bottom bits
  typedef struct packed {
    logic [14:0] day;
    logic [4:0]  hr;
    logic [5:0]  min;
    logic [5:0]  sec;
  } ptime_t;

  localparam int TIME_W = $bits(ptime_t);
  localparam int STAT_W = 16;

  // Status bit positions
  localparam int ST_SWATCH = 0;
  localparam int ST_ALARM  = 1;
  localparam int ST_SEC    = 2;
  localparam int ST_MIN    = 3;
  localparam int ST_HOUR   = 4;
  localparam int ST_DAY    = 5;
  localparam int ST_DALARM = 6;

  localparam logic [5:0] SEC_TOP = 6'd59;
  localparam logic [5:0] MIN_TOP = 6'd59;
  localparam logic [4:0] HR_TOP  = 5'd23;

  typedef enum logic [2:0] {
    A_TIME   = 3'd0,
    A_CTRL   = 3'd1,
    A_ALARM  = 3'd2,
    A_SWATCH = 3'd3,
    A_STATUS = 3'd4,
    A_IEN    = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int DIV = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic pulse_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (!en_i)
      cnt_d = '0;
    else if (pulse_i)
      cnt_d = at_last ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = pulse_i & (~en_i | at_last);
endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   tick_i,
  input  logic   ld_i,
  input  ptime_t ld_val_i,
  output ptime_t time_o,
  output ptime_t time_inc_o,
  output logic   evt_sec_o,
  output logic   evt_min_o,
  output logic   evt_hour_o,
  output logic   evt_day_o
);
  ptime_t time_q, time_d, inc;
  logic   sec_wrap, min_wrap, hr_wrap;

  assign sec_wrap = (time_q.sec >= SEC_TOP);
  assign min_wrap = sec_wrap & (time_q.min >= MIN_TOP);
  assign hr_wrap  = min_wrap & (time_q.hr >= HR_TOP);

  always_comb begin
    inc     = time_q;
    inc.sec = sec_wrap ? '0 : time_q.sec + 1'b1;
    if (sec_wrap) inc.min = (time_q.min >= MIN_TOP) ? '0 : time_q.min + 1'b1;
    if (min_wrap) inc.hr  = (time_q.hr >= HR_TOP) ? '0 : time_q.hr + 1'b1;
    if (hr_wrap)  inc.day = time_q.day + 1'b1;
  end

  always_comb begin
    time_d = time_q;
    if (ld_i)        time_d = ld_val_i;
    else if (tick_i) time_d = inc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else         time_q <= time_d;
  end

  assign time_o     = time_q;
  assign time_inc_o = inc;
  assign evt_sec_o  = tick_i;
  assign evt_min_o  = tick_i & sec_wrap;
  assign evt_hour_o = tick_i & min_wrap;
  assign evt_day_o  = tick_i & hr_wrap;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
(
  input  logic   tick_i,
  input  ptime_t next_i,
  input  ptime_t alarm_i,
  output logic   evt_tod_o,
  output logic   evt_full_o
);
  logic tod_eq, day_eq;

  assign tod_eq     = (next_i.hr == alarm_i.hr) && (next_i.min == alarm_i.min) &&
                      (next_i.sec == alarm_i.sec);
  assign day_eq     = (next_i.day == alarm_i.day);
  assign evt_tod_o  = tick_i & tod_eq;
  assign evt_full_o = tick_i & tod_eq & day_eq;
endmodule

// File: rtl/rtc_stopwatch.sv
module rtc_stopwatch #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         evt_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         live;

  assign live = (cnt_q != '0);

  always_comb begin
    cnt_d = cnt_q;
    if (ld_i)                cnt_d = ld_val_i;
    else if (tick_i && live) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign evt_o = tick_i & ~ld_i & (cnt_q == ONE);
endmodule

// File: rtl/rtc_event_regs.sv
module rtc_event_regs #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] clr_mask_i,
  input  logic         ien_we_i,
  input  logic [W-1:0] ien_val_i,
  output logic [W-1:0] stat_o,
  output logic [W-1:0] ien_o,
  output logic         irq_o
);
  logic [W-1:0] stat_q, stat_d, ien_q, ien_d;

  always_comb begin
    stat_d = stat_q;
    if (clr_we_i) stat_d = stat_d & ~clr_mask_i;
    stat_d = stat_d | set_i;
    ien_d  = ien_we_i ? ien_val_i : ien_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      stat_q <= stat_d;
      ien_q  <= ien_d;
    end
  end

  assign stat_o = stat_q;
  assign ien_o  = ien_q;
  assign irq_o  = |(stat_q & ien_q);
endmodule

// File: rtl/rtc_packed_core.sv
module rtc_packed_core
  import rtc_pkg::*;
#(
  parameter int PRESCALE_DIV = 32768,
  parameter int SWATCH_W     = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick32k_i,
  input  logic        reg_wr_i,
  input  logic [2:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o
);
  logic                pren_q, pren_d;
  ptime_t              alarm_q, alarm_d;
  logic                tick;
  logic                ld_time, ld_alarm, ld_ctrl, ld_sw, stat_clr, ld_ien;
  ptime_t              time_q, time_inc;
  logic                evt_sec, evt_min, evt_hour, evt_day, evt_tod, evt_full, evt_sw;
  logic [SWATCH_W-1:0] sw_cnt;
  logic [STAT_W-1:0]   set_vec, stat_q, ien_q;

  // Write decode
  assign ld_time  = reg_wr_i && (reg_addr_i == A_TIME);
  assign ld_ctrl  = reg_wr_i && (reg_addr_i == A_CTRL);
  assign ld_alarm = reg_wr_i && (reg_addr_i == A_ALARM);
  assign ld_sw    = reg_wr_i && (reg_addr_i == A_SWATCH);
  assign stat_clr = reg_wr_i && (reg_addr_i == A_STATUS);
  assign ld_ien   = reg_wr_i && (reg_addr_i == A_IEN);

  always_comb begin
    pren_d  = ld_ctrl  ? reg_wdata_i[0]       : pren_q;
    alarm_d = ld_alarm ? ptime_t'(reg_wdata_i) : alarm_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pren_q  <= 1'b0;
      alarm_q <= '0;
    end else begin
      pren_q  <= pren_d;
      alarm_q <= alarm_d;
    end
  end

  rtc_prescaler #(.DIV(PRESCALE_DIV)) u_pre (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(pren_q), .pulse_i(tick32k_i), .tick_o(tick)
  );

  rtc_time_counter u_time (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .ld_i(ld_time),
    .ld_val_i(ptime_t'(reg_wdata_i)), .time_o(time_q), .time_inc_o(time_inc),
    .evt_sec_o(evt_sec), .evt_min_o(evt_min), .evt_hour_o(evt_hour), .evt_day_o(evt_day)
  );

  rtc_alarm_cmp u_alarm (
    .tick_i(tick), .next_i(time_inc), .alarm_i(alarm_q),
    .evt_tod_o(evt_tod), .evt_full_o(evt_full)
  );

  rtc_stopwatch #(.W(SWATCH_W)) u_sw (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .ld_i(ld_sw),
    .ld_val_i(reg_wdata_i[SWATCH_W-1:0]), .cnt_o(sw_cnt), .evt_o(evt_sw)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[ST_SWATCH] = evt_sw;
    set_vec[ST_ALARM]  = evt_tod;
    set_vec[ST_SEC]    = evt_sec;
    set_vec[ST_MIN]    = evt_min;
    set_vec[ST_HOUR]   = evt_hour;
    set_vec[ST_DAY]    = evt_day;
    set_vec[ST_DALARM] = evt_full;
  end

  rtc_event_regs #(.W(STAT_W)) u_evt (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_vec),
    .clr_we_i(stat_clr), .clr_mask_i(reg_wdata_i[STAT_W-1:0]),
    .ien_we_i(ld_ien), .ien_val_i(reg_wdata_i[STAT_W-1:0]),
    .stat_o(stat_q), .ien_o(ien_q), .irq_o(irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      A_TIME:   reg_rdata_o = time_q;
      A_CTRL:   reg_rdata_o = {31'd0, pren_q};
      A_ALARM:  reg_rdata_o = alarm_q;
      A_SWATCH: reg_rdata_o = 32'(sw_cnt);
      A_STATUS: reg_rdata_o = 32'(stat_q);
      A_IEN:    reg_rdata_o = 32'(ien_q);
      default:  reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/rtc_packed_chk.sv
module rtc_packed_chk
  import rtc_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tick,
  input logic        tick32k_i,
  input logic        pren_q,
  input logic        ld_time,
  input ptime_t      time_q,
  input logic [15:0] stat_q,
  input logic        stat_clr,
  input logic [15:0] ien_q,
  input logic        irq_o
);
  AST_TIME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick && !ld_time) |=> $stable(time_q)); // R4

  AST_DIRECT_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pren_q && !tick32k_i) |-> !tick); // R4

  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !ld_time && time_q.sec < 6'd59) |=> (time_q.sec == $past(time_q.sec) + 6'd1)); // R2

  AST_MIN_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick && !ld_time && time_q.sec >= 6'd59) |=> stat_q[ST_MIN]); // R5

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_clr |=> ((stat_q & $past(stat_q)) == $past(stat_q))); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == 16'd0) |-> !irq_o); // R9
endmodule

bind rtc_packed_core rtc_packed_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick(tick), .tick32k_i(tick32k_i),
  .pren_q(pren_q), .ld_time(ld_time), .time_q(time_q), .stat_q(stat_q),
  .stat_clr(stat_clr), .ien_q(ien_q), .irq_o(irq_o)
);

// File: tb/sim_rtc_packed_core.sv
module sim_rtc_packed_core;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick32k = 1'b0;
  logic        wr = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rtc_packed_core #(.PRESCALE_DIV(DIV), .SWATCH_W(16)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick32k_i(tick32k), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [31:0] mk(int d, int h, int m, int s);
    return {15'(d), 5'(h), 6'(m), 6'(s)};
  endfunction

  function automatic logic [31:0] m_next(logic [31:0] t);
    int s = int'(t[5:0]), m = int'(t[11:6]), h = int'(t[16:12]), d = int'(t[31:17]);
    if (s >= 59) begin
      s = 0;
      if (m >= 59) begin
        m = 0;
        if (h >= 23) begin h = 0; d = (d + 1) % 32768; end
        else h = h + 1;
      end else m = m + 1;
    end else s = s + 1;
    return mk(d, h, m, s);
  endfunction

  function automatic logic [31:0] m_events(logic [31:0] t, logic [31:0] al);
    logic [31:0] n = m_next(t);
    logic [31:0] e = 32'h4;
    if (t[5:0] >= 59) begin
      e[3] = 1'b1;
      if (t[11:6] >= 59) begin
        e[4] = 1'b1;
        if (t[16:12] >= 23) e[5] = 1'b1;
      end
    end
    if (n[16:0] == al[16:0]) e[1] = 1'b1;
    if (n == al) e[6] = 1'b1;
    return e;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wreg(logic [2:0] a, logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(logic [2:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick32k = 1'b1;
      @(negedge clk); tick32k = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, t, al, acc, st;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rreg(3'd0, v); chk("R1 time reset", v, 0);
    rreg(3'd1, v); chk("R1 ctrl reset", v, 0);
    rreg(3'd2, v); chk("R1 alarm reset", v, 0);
    rreg(3'd4, v); chk("R1 status reset", v, 0);
    rreg(3'd5, v); chk("R1 enable reset", v, 0);
    chk("R1 irq reset", 32'(irq), 0);

    // R2 / R5 full carry into day
    al = mk(0, 12, 0, 0); wreg(3'd2, al);
    t = mk(5, 23, 59, 59); wreg(3'd0, t); wreg(3'd4, 32'hFFFF);
    pulse(1);
    rreg(3'd0, v); chk("R2 carry to day", v, mk(6, 0, 0, 0));
    rreg(3'd4, v); chk("R5 all rollover events", v, 32'h3C);

    // R3 day wrap
    t = mk(32767, 23, 59, 59); wreg(3'd0, t); wreg(3'd4, 32'hFFFF);
    pulse(1);
    rreg(3'd0, v); chk("R3 day wraps to zero", v, 0);
    rreg(3'd4, v); chk("R3 no extra event", v, m_events(t, al));

    // R4 prescaler
    wreg(3'd0, 0); wreg(3'd1, 1);
    pulse(DIV - 1);
    rreg(3'd0, v); chk("R4 no tick before divide", v, 0);
    pulse(1);
    rreg(3'd0, v); chk("R4 tick after divide", v, mk(0, 0, 0, 1));
    wreg(3'd1, 0);
    pulse(1);
    rreg(3'd0, v); chk("R4 direct tick", v, mk(0, 0, 0, 2));

    // R6 time-of-day alarm
    al = mk(9, 10, 20, 30); wreg(3'd2, al);
    wreg(3'd0, mk(2, 10, 20, 29)); wreg(3'd4, 32'hFFFF);
    pulse(1);
    rreg(3'd4, v); chk("R6 tod alarm only", v & 32'h42, 32'h02);

    // R7 full alarm
    wreg(3'd0, mk(9, 10, 20, 29)); wreg(3'd4, 32'hFFFF);
    pulse(1);
    rreg(3'd4, v); chk("R7 day alarm", v & 32'h42, 32'h42);

    // R8 stopwatch
    wreg(3'd3, 3); wreg(3'd4, 32'hFFFF);
    pulse(2);
    rreg(3'd4, v); chk("R8 no event early", v & 1, 0);
    rreg(3'd3, v); chk("R8 countdown", v, 1);
    pulse(1);
    rreg(3'd4, v); chk("R8 event at zero", v & 1, 1);
    rreg(3'd3, v); chk("R8 reached zero", v, 0);
    wreg(3'd4, 32'hFFFF);
    pulse(1);
    rreg(3'd4, v); chk("R8 zero holds quiet", v & 1, 0);
    rreg(3'd3, v); chk("R8 zero holds", v, 0);

    // R9 gating; status from last tick holds bit 2
    rreg(3'd4, st); chk("R9 set while disabled", st & 4, 4);
    chk("R9 irq masked", 32'(irq), 0);
    wreg(3'd5, 32'h8); #1;
    chk("R9 enabled bit without status", 32'(irq), 0);
    wreg(3'd5, 32'h4); #1;
    chk("R9 irq enabled", 32'(irq), 1);

    // R10 write-one-to-clear
    wreg(3'd4, 32'h4);
    rreg(3'd4, v); chk("R10 selective clear", v, st & ~32'h4);
    chk("R10 irq drops", 32'(irq), 0);
    wreg(3'd5, 0);

    // R2 / R5 / R6 / R7 random times against the model
    for (int it = 0; it < 40; it++) begin
      int np;
      t  = mk(int'($urandom % 32768), int'($urandom % 24), int'($urandom % 60), int'($urandom % 60));
      if (it % 4 == 0) t[5:0] = 6'd59;
      if (it % 8 == 0) t[11:6] = 6'd59;
      al = ((it % 3) == 0) ? m_next(t) : mk(int'($urandom % 32768), int'($urandom % 24), 0, 0);
      wreg(3'd2, al); wreg(3'd0, t); wreg(3'd4, 32'hFFFF);
      np = 1 + int'($urandom % 3);
      acc = 0;
      for (int k = 0; k < np; k++) begin
        acc = acc | m_events(t, al);
        t = m_next(t);
      end
      pulse(np);
      rreg(3'd0, v); chk("R2 random advance", v, t);
      rreg(3'd4, v); chk("R5 random events", v, acc);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule